// File: doc/BRIEF.md
# Integer Multiply/Divide and Load Interlock

This block sits beside the issue stage of an in-order integer pipeline. It decides, one cycle at a time, whether the instruction offered for issue may go or must wait. Each operation class has a fixed result latency and a fixed repeat interval. When an operation issues, the block loads countdown trackers from these values. A later instruction that would collide with a tracker that is still running raises `stall`. The pipeline then holds that same instruction and offers it again on the next cycle. Nothing is reordered and nothing is queued: the pipeline slips until the resource or result is ready.

There are four trackers. The first covers occupancy of the multiply/divide unit. The second covers availability of the multiply/divide result. The third covers availability of the most recent load's data. The fourth covers the repeat interval shared by branches and jumps. Multiply and divide are not pipelined, so their repeat interval equals their latency. Loads and stores can follow each other on every cycle. The arithmetic itself, cache misses and floating-point timing are handled elsewhere.

Top module: `intlat_interlock`

## Requirements
- R1: `issue_op` encodes the operation class as ALU=0, LOAD=1, STORE=2, BRANCH=3, JUMP=4, MUL32=5, MUL64=6, DIV32=7, DIV64=8. Reset is asynchronous and active low. After reset, no request of any kind stalls.
- R2: A 32-bit multiply that issues in cycle c makes the unit busy and its result pending until cycle c+8. In cycles c+1 to c+7, a multiply/divide request or a result read stalls. In cycle c+8 the same request goes.
- R3: A 64-bit multiply holds the unit and the result for 12 cycles. The timing is the same as in R2, with 12 in place of 8.
- R4: A 32-bit divide holds the unit and the result for 36 cycles.
- R5: A 64-bit divide holds the unit and the result for 68 cycles.
- R6: Loads and stores that do not read a pending result never stall, including when they come back to back.
- R7: An instruction that reads a loaded value (`issue_rd_load`) in the cycle right after the load issues stalls for exactly one cycle. Two or more cycles after the load, it goes at once.
- R8: ALU operations that read no pending value never stall, even while a divide is in progress. They load no tracker.
- R9: A branch or jump that issues in cycle c makes a branch or jump offered in cycle c+1 stall for one cycle. Non-control operations offered in that cycle go.
- R10: While `stall` is high, `issue_go` is low and no tracker is reloaded. `issue_go` equals `issue_vld` whenever `stall` is low.
- R11: The trackers count down once per clock whether or not the pipeline is stalled. A multiply/divide held back by a busy unit therefore issues exactly in the cycle the previous interval expires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_vld | input | 1 | An instruction is offered for issue this cycle |
| issue_op | input | 4 | Operation class of the offered instruction (encoding in R1) |
| issue_rd_md | input | 1 | The offered instruction reads the multiply/divide result |
| issue_rd_load | input | 1 | The offered instruction reads the destination of the last load |
| stall | output | 1 | The offered instruction must be held and offered again |
| issue_go | output | 1 | The offered instruction issues this cycle |

## Verification
The bench aims at the exact release cycle of each interval.

- **Off-by-one interval.** If a tracker were loaded with the full latency instead of latency minus one, each multiply or divide would cost one extra stall cycle, and the per-operation stall counts (7, 11, 35, 67) would be off by one.
- **Counting paused during a stall.** A design that froze its trackers while stalled would hold back a divide queued behind a multiply past its due cycle.
- **Load and control timing.** The bench checks that the load-use and branch-after-branch stalls last one cycle. It also checks that back-to-back memory operations and ALU work beside a running divide are never held. A design that shared trackers between classes would stall there.
- **Reset in mid-interval.** A reset during a divide must clear every pending interval at once.

// File: rtl/intlat_pkg.sv
package intlat_pkg;

  typedef enum logic [3:0] {
    OPC_ALU    = 4'd0,
    OPC_LOAD   = 4'd1,
    OPC_STORE  = 4'd2,
    OPC_BRANCH = 4'd3,
    OPC_JUMP   = 4'd4,
    OPC_MUL32  = 4'd5,
    OPC_MUL64  = 4'd6,
    OPC_DIV32  = 4'd7,
    OPC_DIV64  = 4'd8
  } opc_e;

  localparam int NUM_TRK    = 4;
  localparam int TRK_MD_OCC = 0;  // multiply/divide unit occupancy
  localparam int TRK_MD_RES = 1;  // multiply/divide result pending
  localparam int TRK_LD_RES = 2;  // load data pending
  localparam int TRK_CTL    = 3;  // branch/jump repeat

  function automatic logic opc_is_md(input logic [3:0] op);
    return (op == OPC_MUL32) || (op == OPC_MUL64) ||
           (op == OPC_DIV32) || (op == OPC_DIV64);
  endfunction

  function automatic logic opc_is_ctl(input logic [3:0] op);
    return (op == OPC_BRANCH) || (op == OPC_JUMP);
  endfunction

endpackage

// File: rtl/intlat_decode.sv
module intlat_decode
  import intlat_pkg::*;
#(
  parameter int LAT_MUL32 = 8,
  parameter int LAT_MUL64 = 12,
  parameter int LAT_DIV32 = 36,
  parameter int LAT_DIV64 = 68,
  parameter int LAT_LOAD  = 2,
  parameter int REP_CTL   = 2,
  parameter int CNT_W     = 7
) (
  input  logic                            fire,
  input  logic [3:0]                      op,
  output logic [NUM_TRK-1:0]              trk_ld,
  output logic [NUM_TRK-1:0][CNT_W-1:0]   trk_val
);

  // A tracker loaded with N-1 reaches zero N cycles after issue.
  localparam logic [CNT_W-1:0] V_MUL32 = CNT_W'(LAT_MUL32 - 1);
  localparam logic [CNT_W-1:0] V_MUL64 = CNT_W'(LAT_MUL64 - 1);
  localparam logic [CNT_W-1:0] V_DIV32 = CNT_W'(LAT_DIV32 - 1);
  localparam logic [CNT_W-1:0] V_DIV64 = CNT_W'(LAT_DIV64 - 1);
  localparam logic [CNT_W-1:0] V_LOAD  = CNT_W'(LAT_LOAD - 1);
  localparam logic [CNT_W-1:0] V_CTL   = CNT_W'(REP_CTL - 1);

  logic [CNT_W-1:0] md_val;

  always_comb begin
    unique case (op)
      OPC_MUL64: md_val = V_MUL64;
      OPC_DIV32: md_val = V_DIV32;
      OPC_DIV64: md_val = V_DIV64;
      default:   md_val = V_MUL32;
    endcase
  end

  always_comb begin
    trk_ld  = '0;
    trk_val = '0;
    trk_val[TRK_MD_OCC] = md_val;
    trk_val[TRK_MD_RES] = md_val;
    trk_val[TRK_LD_RES] = V_LOAD;
    trk_val[TRK_CTL]    = V_CTL;
    if (fire) begin
      trk_ld[TRK_MD_OCC] = opc_is_md(op);
      trk_ld[TRK_MD_RES] = opc_is_md(op);
      trk_ld[TRK_LD_RES] = (op == OPC_LOAD);
      trk_ld[TRK_CTL]    = opc_is_ctl(op);
    end
  end

endmodule

// File: rtl/intlat_countdown.sv
module intlat_countdown #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             busy
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic             cnt_en;

  assign busy   = (cnt_q != '0);
  assign cnt_en = ld | busy;
  assign cnt    = cnt_q;

  always_comb begin
    if (ld) begin
      cnt_nx = ld_val;
    end else begin
      cnt_nx = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nx;
    end
  end

endmodule

// File: rtl/intlat_interlock.sv
module intlat_interlock
  import intlat_pkg::*;
#(
  parameter int LAT_MUL32 = 8,
  parameter int LAT_MUL64 = 12,
  parameter int LAT_DIV32 = 36,
  parameter int LAT_DIV64 = 68,
  parameter int LAT_LOAD  = 2,
  parameter int REP_CTL   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       issue_vld,
  input  logic [3:0] issue_op,
  input  logic       issue_rd_md,
  input  logic       issue_rd_load,
  output logic       stall,
  output logic       issue_go
);

  localparam int MAX_A   = (LAT_MUL32 > LAT_MUL64) ? LAT_MUL32 : LAT_MUL64;
  localparam int MAX_B   = (LAT_DIV32 > LAT_DIV64) ? LAT_DIV32 : LAT_DIV64;
  localparam int MAX_C   = (LAT_LOAD  > REP_CTL)   ? LAT_LOAD  : REP_CTL;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_LAT = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  logic [NUM_TRK-1:0]            trk_ld;
  logic [NUM_TRK-1:0][CNT_W-1:0] trk_val;
  logic [NUM_TRK-1:0][CNT_W-1:0] trk_cnt;
  logic [NUM_TRK-1:0]            trk_busy;

  logic hit_md_occ;
  logic hit_md_res;
  logic hit_ld_res;
  logic hit_ctl;

  intlat_decode #(
    .LAT_MUL32 (LAT_MUL32),
    .LAT_MUL64 (LAT_MUL64),
    .LAT_DIV32 (LAT_DIV32),
    .LAT_DIV64 (LAT_DIV64),
    .LAT_LOAD  (LAT_LOAD),
    .REP_CTL   (REP_CTL),
    .CNT_W     (CNT_W)
  ) u_decode (
    .fire    (issue_go),
    .op      (issue_op),
    .trk_ld  (trk_ld),
    .trk_val (trk_val)
  );

  for (genvar g = 0; g < NUM_TRK; g++) begin : g_trk
    intlat_countdown #(
      .CNT_W (CNT_W)
    ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (trk_ld[g]),
      .ld_val (trk_val[g]),
      .cnt    (trk_cnt[g]),
      .busy   (trk_busy[g])
    );
  end

  always_comb begin
    hit_md_occ = opc_is_md(issue_op)  & trk_busy[TRK_MD_OCC];
    hit_md_res = issue_rd_md          & trk_busy[TRK_MD_RES];
    hit_ld_res = issue_rd_load        & trk_busy[TRK_LD_RES];
    hit_ctl    = opc_is_ctl(issue_op) & trk_busy[TRK_CTL];
    stall      = issue_vld & (hit_md_occ | hit_md_res | hit_ld_res | hit_ctl);
    issue_go   = issue_vld & ~stall;
  end

endmodule

// File: rtl/intlat_interlock_chk.sv
module intlat_interlock_chk
  import intlat_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_vld,
  input logic [3:0]       issue_op,
  input logic             issue_rd_md,
  input logic             issue_rd_load,
  input logic             stall,
  input logic             issue_go,
  input logic [CNT_W-1:0] occ_cnt,
  input logic             occ_ld
);

  p_stall_blocks_go_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !issue_go);

  p_go_when_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && !stall) |-> issue_go);

  p_md_repeat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_go && opc_is_md(issue_op)) |=>
      !(issue_vld && opc_is_md(issue_op) && issue_go));

  p_load_use_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_go && issue_op == OPC_LOAD) |=> ((issue_vld && issue_rd_load) -> stall));

  p_ctl_repeat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_go && opc_is_ctl(issue_op)) |=>
      ((issue_vld && opc_is_ctl(issue_op)) -> stall));

  p_alu_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && issue_op == OPC_ALU && !issue_rd_md && !issue_rd_load) |-> !stall);

  p_mem_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && (issue_op == OPC_LOAD || issue_op == OPC_STORE) &&
     !issue_rd_md && !issue_rd_load) |-> !stall);

  p_count_through_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_cnt != '0 && !occ_ld) |=> (occ_cnt == $past(occ_cnt) - 1'b1));

endmodule

bind intlat_interlock intlat_interlock_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .issue_vld     (issue_vld),
  .issue_op      (issue_op),
  .issue_rd_md   (issue_rd_md),
  .issue_rd_load (issue_rd_load),
  .stall         (stall),
  .issue_go      (issue_go),
  .occ_cnt       (trk_cnt[0]),
  .occ_ld        (trk_ld[0])
);

// File: tb/intlat_interlock_bench.sv
module intlat_interlock_bench;

  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] OP_ALU = 4'd0, OP_LOAD = 4'd1, OP_STORE = 4'd2,
                         OP_BR  = 4'd3, OP_JMP  = 4'd4, OP_MUL32 = 4'd5,
                         OP_MUL64 = 4'd6, OP_DIV32 = 4'd7, OP_DIV64 = 4'd8;

  logic       clk;
  logic       rst_n;
  logic       issue_vld;
  logic [3:0] issue_op;
  logic       issue_rd_md;
  logic       issue_rd_load;
  logic       stall;
  logic       issue_go;

  intlat_interlock u_intlat_interlock (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_vld     (issue_vld),
    .issue_op      (issue_op),
    .issue_rd_md   (issue_rd_md),
    .issue_rd_load (issue_rd_load),
    .stall         (stall),
    .issue_go      (issue_go)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  longint cyc  = 0;
  bit done     = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Independent model: the cycle at which each resource becomes free.
  longint occ_free, res_free, ld_free, ctl_free;

  typedef struct {
    logic  exp_stall;
    logic  exp_go;
    string tag;
  } item_t;
  item_t sb_q[$];

  function automatic int lat_of(input logic [3:0] op);
    case (op)
      OP_MUL32: return 8;
      OP_MUL64: return 12;
      OP_DIV32: return 36;
      default:  return 68;
    endcase
  endfunction

  task automatic model_reset();
    occ_free = 0; res_free = 0; ld_free = 0; ctl_free = 0;
  endtask

  task automatic check_int(input longint act, input longint exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: drive one cycle and push the expected response.
  task automatic drive(input logic vld, input logic [3:0] op, input logic rmd,
                       input logic rld, input string tag, output logic exp_st);
    item_t it;
    logic is_md, is_ctl;
    @(negedge clk);
    issue_vld = vld; issue_op = op; issue_rd_md = rmd; issue_rd_load = rld;
    is_md  = (op >= OP_MUL32) && (op <= OP_DIV64);
    is_ctl = (op == OP_BR) || (op == OP_JMP);
    exp_st = vld && ((is_md && cyc < occ_free) || (rmd && cyc < res_free) ||
                     (rld && cyc < ld_free) || (is_ctl && cyc < ctl_free));
    it.exp_stall = exp_st;
    it.exp_go    = vld && !exp_st;
    it.tag       = tag;
    sb_q.push_back(it);
    if (vld && !exp_st) begin
      if (is_md) begin
        occ_free = cyc + lat_of(op);
        res_free = cyc + lat_of(op);
      end
      if (op == OP_LOAD) ld_free  = cyc + 2;
      if (is_ctl)        ctl_free = cyc + 2;
    end
  endtask

  // Offer an op until it issues; return how many cycles it stalled.
  task automatic send(input logic [3:0] op, input logic rmd, input logic rld,
                      input string tag, output int nst);
    logic st;
    nst = 0;
    for (int k = 0; k < 100; k++) begin
      drive(1'b1, op, rmd, rld, tag, st);
      if (!st) break;
      nst++;
    end
  endtask

  task automatic idle(input int n);
    logic st;
    for (int k = 0; k < n; k++) drive(1'b0, OP_ALU, 1'b0, 1'b0, "idle", st);
  endtask

  // Monitor: pop and compare after the driver has settled the inputs.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_checks++;
        if (stall !== it.exp_stall || issue_go !== it.exp_go) begin
          n_fails++;
          $display("FAIL %s: actual stall=%b go=%b expected stall=%b go=%b",
                   it.tag, stall, issue_go, it.exp_stall, it.exp_go);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic st;
    issue_vld = 0; issue_op = OP_ALU; issue_rd_md = 0; issue_rd_load = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: nothing stalls right after reset
    drive(1'b1, OP_ALU, 1'b1, 1'b1, "R1 reset read", st);
    check_int(st, 0, "R1 model");
    idle(1);

    // R2: mul32 then result read: 7 stall cycles
    send(OP_MUL32, 0, 0, "R2 mul32 issue", n);
    send(OP_ALU, 1, 0, "R2 mul32 result read", n);
    check_int(n, 7, "R2 read stall count");

    // R3: mul64 then another mul64
    send(OP_MUL64, 0, 0, "R3 mul64 issue", n);
    send(OP_MUL64, 0, 0, "R3 mul64 repeat", n);
    check_int(n, 11, "R3 repeat stall count");
    idle(12);

    // R4 + R8: div32 with ALU work alongside, then result read
    send(OP_DIV32, 0, 0, "R4 div32 issue", n);
    for (int k = 0; k < 5; k++) drive(1'b1, OP_ALU, 0, 0, "R8 alu beside divide", st);
    send(OP_ALU, 1, 0, "R4 div32 result read", n);
    check_int(n, 30, "R4 read stall count");

    // R5: div64 repeat
    send(OP_DIV64, 0, 0, "R5 div64 issue", n);
    send(OP_DIV32, 0, 0, "R5 div64 repeat", n);
    check_int(n, 67, "R5 repeat stall count");
    idle(36);

    // R11: counting continues while a divide is held back behind a multiply
    send(OP_MUL32, 0, 0, "R11 mul issue", n);
    idle(3);
    send(OP_DIV32, 0, 0, "R11 div held", n);
    check_int(n, 4, "R11 release cycle");
    idle(36);

    // R6: back-to-back memory ops
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, OP_LOAD,  0, 0, "R6 load b2b", st);
      drive(1'b1, OP_STORE, 0, 0, "R6 store b2b", st);
    end

    // R7: load-use next cycle stalls one; after a gap no stall
    send(OP_LOAD, 0, 0, "R7 load", n);
    send(OP_ALU, 0, 1, "R7 load use", n);
    check_int(n, 1, "R7 load-use stall count");
    send(OP_LOAD, 0, 0, "R7 load 2", n);
    idle(1);
    send(OP_ALU, 0, 1, "R7 late use", n);
    check_int(n, 0, "R7 late use stall count");

    // R9: control after control
    send(OP_BR, 0, 0, "R9 branch", n);
    send(OP_JMP, 0, 0, "R9 jump after branch", n);
    check_int(n, 1, "R9 control stall count");
    send(OP_ALU, 0, 0, "R9 alu after jump", n);
    check_int(n, 0, "R9 alu not held");

    // R10: stalled mul is not issued; a held op does not reload trackers
    send(OP_MUL32, 0, 0, "R10 mul issue", n);
    drive(1'b1, OP_DIV64, 0, 0, "R10 held div", st);
    check_int(st, 1, "R10 held div stalls");
    drive(1'b0, OP_ALU, 0, 0, "R10 withdraw", st);
    idle(5);
    send(OP_ALU, 1, 0, "R10 read after mul only", n);
    check_int(n, 0, "R10 no reload by held op");

    // R1: reset in the middle of a divide clears all intervals
    send(OP_DIV64, 0, 0, "R1 div64 before reset", n);
    idle(4);
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    model_reset();
    send(OP_MUL64, 1, 0, "R1 after reset", n);
    check_int(n, 0, "R1 no stall after reset");
    idle(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule